// File: doc/BRIEF.md
# Four-Channel DMA Byte-Port Register File

This block is the register front end of a four-channel DMA engine as it appears on an 8-bit I/O bus. It decodes a sixteen-entry port space. Each channel has a 16-bit start address and a 16-bit transfer count. Both are held twice: once as a base copy and once as a working copy. All of these registers are reached through 8-bit ports. One shared pointer bit decides whether an access reaches the low byte or the high byte.

Alongside the channel registers it holds per-channel mask and mode bits, a command byte, software request bits and per-channel terminal-count flags. The transfer engine sits outside this block. It pulses one step strobe per channel for each completed transfer. On each pulse the block advances the working address, decrements the working count, and signals terminal count when the count wraps. The engine reads the resulting configuration from the output ports.

Top module: `dma_regif`

## Requirements
- R1: After reset the pointer selects the low byte. Every read or write of a channel port (offsets 0x0-0x7) accesses the byte the pointer selects and then flips the pointer, so a 16-bit value moves as low byte then high byte.
- R2: A write of any data to offset 0xC returns the pointer to the low byte.
- R3: Channel n has its address at offset 2n and its count at offset 2n+1. A byte written there goes into both the base and the working copy. A read returns the working copy.
- R4: A write to offset 0xA selects a channel with data bits 1:0. Data bit 2 set masks that channel and bit 2 clear unmasks it. `chMask` bit n is channel n's mask.
- R5: A write to offset 0xF loads all four mask bits from data bits 3:0. A write to offset 0xE clears all four.
- R6: A write to offset 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as that channel's mode, presented on `chMode[6n+5:6n]`. Mode bit 2 (data 0x10) enables autoinitialize. Mode bit 3 (data 0x20) makes the address decrement. Mode bits 5:4 equal to 11 (data 0xC0) select cascade.
- R7: A step strobe on a non-cascade channel decrements its working count and moves its working address by one, upward unless mode bit 3 is set. A bus write to that channel's address or count in the same cycle takes priority over the step.
- R8: A step while the working count is 0 produces terminal count. `tcOut[n]` pulses high for one cycle in the following cycle, and the channel's status flag is set one cycle after that. Without autoinitialize the count reads 0xFFFF afterwards. With autoinitialize both working copies reload from their base copies.
- R9: A read of offset 0x8 returns request bits in data bits 7:4 and terminal-count flags in bits 3:0, then clears the terminal-count flags. A write to offset 0x8 loads `chCmd`.
- R10: A write to offset 0x9 selects a channel with data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's request bit on `chReq`.
- R11: A write to offset 0xD resets the pointer to low, sets all mask bits, and clears command, request and terminal-count flags. Mode, address and count are kept. A read of offset 0xD returns 0x00.
- R12: Reset leaves all masks set and mode, command, request, flags, addresses and counts at zero.
- R13: Step strobes on a channel in cascade mode leave its working address and count unchanged and raise no terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Port offset |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid in the cycle busRd is high |
| stepStb | input | 4 | Per-channel transfer-done strobe |
| tcOut | output | 4 | Per-channel terminal-count pulse |
| chMask | output | 4 | Per-channel mask bits |
| chMode | output | 24 | Six mode bits per channel |
| chCmd | output | 8 | Command byte |
| chReq | output | 4 | Software request bits |
| chAddr | output | 64 | Working address of each channel, 16 bits each |

## Verification
The assertions assume that a read and a write never occur in the same cycle. They also assume that a master clear never arrives in the cycle a terminal-count pulse is landing. With overlapped strobes, the expected pointer and flag transitions would be ambiguous. The stimulus issues one bus access per cycle with the other strobe low. It separates every step burst from later bus traffic with an idle cycle. Random phases draw channels, byte values and step masks freely, but they keep the bus strobes exclusive.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int PORT_W = 4;
  localparam int MODE_W = BYTE_W - CH_W;

  localparam logic [PORT_W-1:0] PORT_CMD     = 4'h8;
  localparam logic [PORT_W-1:0] PORT_REQ     = 4'h9;
  localparam logic [PORT_W-1:0] PORT_MASK1   = 4'hA;
  localparam logic [PORT_W-1:0] PORT_MODE    = 4'hB;
  localparam logic [PORT_W-1:0] PORT_CLRPTR  = 4'hC;
  localparam logic [PORT_W-1:0] PORT_MCLR    = 4'hD;
  localparam logic [PORT_W-1:0] PORT_MASKCLR = 4'hE;
  localparam logic [PORT_W-1:0] PORT_MASKALL = 4'hF;

  localparam int FLAG_BIT      = 2;
  localparam int MODE_AUTO_BIT = 2;
  localparam int MODE_DEC_BIT  = 3;

  typedef struct packed {
    logic [NCH-1:0]    wrAddr;
    logic [NCH-1:0]    wrCnt;
    logic              hiByte;
    logic [BYTE_W-1:0] data;
  } chanStb_t;
endpackage

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
  import dma_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrAddr,
  input  logic              wrCnt,
  input  logic              hiByte,
  input  logic [BYTE_W-1:0] data,
  input  logic              step,
  input  logic              autoInit,
  input  logic              decAddr,
  input  logic              cascade,
  output logic [REG_W-1:0]  curAddr,
  output logic [REG_W-1:0]  curCnt,
  output logic              tcPulse
);
  logic [REG_W-1:0] baseAddr, baseCnt, nextAddr;

  assign nextAddr = decAddr ? curAddr - 1'b1 : curAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      baseCnt  <= '0;
      curAddr  <= '0;
      curCnt   <= '0;
      tcPulse  <= 1'b0;
    end else begin
      tcPulse <= 1'b0;
      if (wrAddr) begin
        if (hiByte) begin
          baseAddr[REG_W-1:BYTE_W] <= data;
          curAddr[REG_W-1:BYTE_W]  <= data;
        end else begin
          baseAddr[BYTE_W-1:0] <= data;
          curAddr[BYTE_W-1:0]  <= data;
        end
      end else if (wrCnt) begin
        if (hiByte) begin
          baseCnt[REG_W-1:BYTE_W] <= data;
          curCnt[REG_W-1:BYTE_W]  <= data;
        end else begin
          baseCnt[BYTE_W-1:0] <= data;
          curCnt[BYTE_W-1:0]  <= data;
        end
      end else if (step && !cascade) begin
        if (curCnt == '0) begin
          tcPulse <= 1'b1;
          if (autoInit) begin
            curAddr <= baseAddr;
            curCnt  <= baseCnt;
          end else begin
            curAddr <= nextAddr;
            curCnt  <= '1;
          end
        end else begin
          curAddr <= nextAddr;
          curCnt  <= curCnt - 1'b1;
        end
      end
    end
  end

  // R3: a written byte lands in both copies
  a_r3_hi_both: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddr && hiByte) |=> (curAddr[REG_W-1:BYTE_W] == baseAddr[REG_W-1:BYTE_W]));
  // R8: wrap without autoinit
  a_r8_tc_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (step && !cascade && !wrAddr && !wrCnt && curCnt == '0 && !autoInit)
    |=> (tcPulse && curCnt == '1));
  // R13: cascade freezes the working copies
  a_r13_cascade_hold: assert property (@(posedge clk) disable iff (!rstN)
    (step && cascade && !wrAddr && !wrCnt) |=> ($stable(curCnt) && $stable(curAddr) && !tcPulse));
endmodule

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl
  import dma_regif_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PORT_W-1:0]             busAddr,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic [BYTE_W-1:0]             busWrData,
  input  logic [NCH-1:0][REG_W-1:0]     curAddr,
  input  logic [NCH-1:0][REG_W-1:0]     curCnt,
  input  logic [NCH-1:0]                tcPulse,
  output chanStb_t                      stb,
  output logic [BYTE_W-1:0]             busRdData,
  output logic [NCH-1:0]                maskOut,
  output logic [NCH-1:0][MODE_W-1:0]    modeOut,
  output logic [BYTE_W-1:0]             cmdOut,
  output logic [NCH-1:0]                reqOut
);
  logic ptrHi;
  logic [NCH-1:0] tcFlags;
  logic isChanPort, isCnt, chanAcc;
  logic [CH_W-1:0] chSel, selCh;
  logic wrCmd, wrReq, wrMask1, wrMode, wrClrPtr, wrMclr, wrMaskClr, wrMaskAll, rdStat;
  logic [NCH-1:0] wrAddrV, wrCntV;
  logic [REG_W-1:0] chWord;

  assign isChanPort = ~busAddr[PORT_W-1];
  assign isCnt      = busAddr[0];
  assign chSel      = busAddr[CH_W:1];
  assign selCh      = busWrData[CH_W-1:0];
  assign chanAcc    = (busWr || busRd) && isChanPort;

  assign wrCmd     = busWr && (busAddr == PORT_CMD);
  assign wrReq     = busWr && (busAddr == PORT_REQ);
  assign wrMask1   = busWr && (busAddr == PORT_MASK1);
  assign wrMode    = busWr && (busAddr == PORT_MODE);
  assign wrClrPtr  = busWr && (busAddr == PORT_CLRPTR);
  assign wrMclr    = busWr && (busAddr == PORT_MCLR);
  assign wrMaskClr = busWr && (busAddr == PORT_MASKCLR);
  assign wrMaskAll = busWr && (busAddr == PORT_MASKALL);
  assign rdStat    = busRd && (busAddr == PORT_CMD);

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign wrAddrV[g] = busWr && isChanPort && !isCnt && (chSel == g);
    assign wrCntV[g]  = busWr && isChanPort &&  isCnt && (chSel == g);
  end

  assign stb.wrAddr = wrAddrV;
  assign stb.wrCnt  = wrCntV;
  assign stb.hiByte = ptrHi;
  assign stb.data   = busWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrHi   <= 1'b0;
      maskOut <= '1;
      modeOut <= '0;
      cmdOut  <= '0;
      reqOut  <= '0;
      tcFlags <= '0;
    end else if (wrMclr) begin
      ptrHi   <= 1'b0;
      maskOut <= '1;
      cmdOut  <= '0;
      reqOut  <= '0;
      tcFlags <= '0;
    end else begin
      if (wrClrPtr) ptrHi <= 1'b0;
      else if (chanAcc) ptrHi <= ~ptrHi;
      if (wrCmd) cmdOut <= busWrData;
      if (wrReq) reqOut[selCh] <= busWrData[FLAG_BIT];
      if (wrMask1) maskOut[selCh] <= busWrData[FLAG_BIT];
      else if (wrMaskAll) maskOut <= busWrData[NCH-1:0];
      else if (wrMaskClr) maskOut <= '0;
      if (wrMode) modeOut[selCh] <= busWrData[BYTE_W-1:CH_W];
      tcFlags <= (rdStat ? '0 : tcFlags) | tcPulse;
    end
  end

  always_comb begin
    chWord    = isCnt ? curCnt[chSel] : curAddr[chSel];
    busRdData = '0;
    if (busRd) begin
      if (isChanPort) busRdData = ptrHi ? chWord[REG_W-1:BYTE_W] : chWord[BYTE_W-1:0];
      else if (busAddr == PORT_CMD) busRdData = {reqOut, tcFlags};
    end
  end

  // R1: each channel-port access flips the pointer
  a_r1_ptr_toggle: assert property (@(posedge clk) disable iff (!rstN)
    chanAcc |=> (ptrHi != $past(ptrHi)));
  // R2: pointer clear
  a_r2_clear_ptr: assert property (@(posedge clk) disable iff (!rstN)
    wrClrPtr |=> !ptrHi);
  // R4: single mask set
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask1 && busWrData[FLAG_BIT]) |=> maskOut[$past(selCh)]);
  // R11: master clear
  a_r11_mclr: assert property (@(posedge clk) disable iff (!rstN)
    wrMclr |=> (maskOut == '1 && cmdOut == '0 && reqOut == '0 && !ptrHi && tcFlags == '0));
  // R9: status read clears flags not freshly raised
  a_r9_stat_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !busWr) |=> ((tcFlags & ~$past(tcPulse)) == '0));
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PORT_W-1:0]       busAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [BYTE_W-1:0]       busWrData,
  output logic [BYTE_W-1:0]       busRdData,
  input  logic [NCH-1:0]          stepStb,
  output logic [NCH-1:0]          tcOut,
  output logic [NCH-1:0]          chMask,
  output logic [NCH*MODE_W-1:0]   chMode,
  output logic [BYTE_W-1:0]       chCmd,
  output logic [NCH-1:0]          chReq,
  output logic [NCH*REG_W-1:0]    chAddr
);
  chanStb_t stb;
  logic [NCH-1:0][REG_W-1:0]  curAddr, curCnt;
  logic [NCH-1:0][MODE_W-1:0] modeOut;

  dma_regif_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .curAddr(curAddr), .curCnt(curCnt), .tcPulse(tcOut),
    .stb(stb), .busRdData(busRdData), .maskOut(chMask), .modeOut(modeOut),
    .cmdOut(chCmd), .reqOut(chReq)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_regif_chan chan_i (
      .clk(clk), .rstN(rstN),
      .wrAddr(stb.wrAddr[g]), .wrCnt(stb.wrCnt[g]), .hiByte(stb.hiByte), .data(stb.data),
      .step(stepStb[g]),
      .autoInit(modeOut[g][MODE_AUTO_BIT]),
      .decAddr(modeOut[g][MODE_DEC_BIT]),
      .cascade(modeOut[g][MODE_W-1:MODE_W-2] == 2'b11),
      .curAddr(curAddr[g]), .curCnt(curCnt[g]), .tcPulse(tcOut[g])
    );
  end

  assign chMode = modeOut;
  assign chAddr = curAddr;
endmodule

// File: tb/dma_regif_tb_top.sv
module dma_regif_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [3:0] stepStb = '0;
  logic [3:0] tcOut, chMask, chReq;
  logic [23:0] chMode;
  logic [7:0] chCmd;
  logic [63:0] chAddr;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  logic [15:0] mBaseA[4], mBaseC[4], mCurA[4], mCurC[4];
  logic [5:0]  mMode[4];
  logic [3:0]  mMask, mReq, mTc;
  logic [7:0]  mCmd;
  logic        mPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regif dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .stepStb(stepStb), .tcOut(tcOut),
    .chMask(chMask), .chMode(chMode), .chCmd(chCmd), .chReq(chReq), .chAddr(chAddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expMode();
    logic [23:0] v;
    for (int i = 0; i < 4; i++) v[i*6 +: 6] = mMode[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mBaseA[i] = '0; mBaseC[i] = '0; mCurA[i] = '0; mCurC[i] = '0; mMode[i] = '0;
    end
    mMask = 4'hF; mReq = '0; mTc = '0; mCmd = '0; mPtr = 1'b0;
  endtask

  task automatic wrPort(input logic [3:0] a, input logic [7:0] d);
    int ch;
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    ch = int'(d[1:0]);
    if (a < 4'h8) begin
      if (a[0]) begin
        if (mPtr) begin mBaseC[a[2:1]][15:8] = d; mCurC[a[2:1]][15:8] = d; end
        else begin mBaseC[a[2:1]][7:0] = d; mCurC[a[2:1]][7:0] = d; end
      end else begin
        if (mPtr) begin mBaseA[a[2:1]][15:8] = d; mCurA[a[2:1]][15:8] = d; end
        else begin mBaseA[a[2:1]][7:0] = d; mCurA[a[2:1]][7:0] = d; end
      end
      mPtr = ~mPtr;
    end else case (a)
      4'h8: mCmd = d;
      4'h9: mReq[ch] = d[2];
      4'hA: mMask[ch] = d[2];
      4'hB: mMode[ch] = d[7:2];
      4'hC: mPtr = 1'b0;
      4'hD: begin mPtr = 1'b0; mMask = 4'hF; mCmd = '0; mReq = '0; mTc = '0; end
      4'hE: mMask = '0;
      default: mMask = d[3:0];
    endcase
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [15:0] w;
    if (a < 4'h8) begin
      w = a[0] ? mCurC[a[2:1]] : mCurA[a[2:1]];
      return mPtr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {mReq, mTc};
    return 8'h00;
  endfunction

  task automatic rdChk(input string req, input logic [3:0] a);
    logic [7:0] e;
    e = expRead(a);
    busAddr = a; busRd = 1'b1;
    #1;
    chk(req, busRdData, e);
    @(negedge clk);
    busRd = 1'b0;
    if (a < 4'h8) mPtr = ~mPtr;
    if (a == 4'h8) mTc = '0;
  endtask

  task automatic stepCh(input logic [3:0] m);
    logic [3:0] eTc;
    eTc = '0;
    for (int i = 0; i < 4; i++) begin
      if (m[i] && mMode[i][5:4] != 2'b11) begin
        if (mCurC[i] == 16'h0) begin
          eTc[i] = 1'b1;
          if (mMode[i][2]) begin mCurA[i] = mBaseA[i]; mCurC[i] = mBaseC[i]; end
          else begin
            mCurA[i] = mMode[i][3] ? mCurA[i] - 16'd1 : mCurA[i] + 16'd1;
            mCurC[i] = 16'hFFFF;
          end
        end else begin
          mCurA[i] = mMode[i][3] ? mCurA[i] - 16'd1 : mCurA[i] + 16'd1;
          mCurC[i] = mCurC[i] - 16'd1;
        end
      end
    end
    stepStb = m;
    @(negedge clk);
    stepStb = '0;
    chk("R8 tcOut", tcOut, eTc);
    mTc |= eTc;
    @(negedge clk);
  endtask

  task automatic chkOuts(input string req);
    chk(req, {chMask, chReq, chCmd, chMode}, {mMask, mReq, mCmd, expMode()});
    for (int i = 0; i < 4; i++) chk(req, chAddr[i*16 +: 16], mCurA[i]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrors++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkOuts("R12 reset outputs");
    rdChk("R12 reset addr low", 4'h0);
    rdChk("R1 second byte high", 4'h0);

    // R1 R3: low then high
    wrPort(4'hC, 8'h5A);
    wrPort(4'h2, 8'h34); wrPort(4'h2, 8'h12);
    rdChk("R3 ch1 addr low", 4'h2); rdChk("R3 ch1 addr high", 4'h2);
    chkOuts("R3 addr out");
    // R2: clear after a half access
    rdChk("R1 half read", 4'h2);
    wrPort(4'hC, 8'hFF);
    rdChk("R2 low after clear", 4'h2);
    wrPort(4'hC, 8'h00);

    // R6 R7 R8 plain run on ch1, count 2 -> three transfers
    wrPort(4'h3, 8'h02); wrPort(4'h3, 8'h00);
    wrPort(4'hB, 8'h45);
    wrPort(4'hA, 8'h01);
    chkOuts("R4 R6 unmask and mode");
    stepCh(4'b0010); stepCh(4'b0010);
    rdChk("R7 count low", 4'h3); rdChk("R7 count high", 4'h3);
    stepCh(4'b0010);
    rdChk("R8 wrapped low", 4'h3); rdChk("R8 wrapped high", 4'h3);
    chkOuts("R7 address advanced");
    rdChk("R9 status tc", 4'h8);
    rdChk("R9 status cleared", 4'h8);

    // R8 autoinit on ch2
    wrPort(4'hB, 8'h56);
    wrPort(4'h4, 8'h00); wrPort(4'h4, 8'h01);
    wrPort(4'h5, 8'h01); wrPort(4'h5, 8'h00);
    stepCh(4'b0100); stepCh(4'b0100);
    rdChk("R8 autoinit count low", 4'h5); rdChk("R8 autoinit count high", 4'h5);
    chkOuts("R8 autoinit address");

    // R6 R7 decrement on ch3, R13 cascade on ch0
    wrPort(4'hB, 8'h6B);
    wrPort(4'h6, 8'h00); wrPort(4'h6, 8'h80);
    wrPort(4'h1, 8'h00); wrPort(4'h1, 8'h00);
    wrPort(4'hB, 8'hC0);
    stepCh(4'b1001);
    chkOuts("R7 R13 decrement and cascade");
    rdChk("R13 cascade count low", 4'h1); rdChk("R13 cascade count high", 4'h1);

    // R10 request, R9 command
    wrPort(4'h9, 8'h06); wrPort(4'h9, 8'h05); wrPort(4'h9, 8'h01);
    wrPort(4'h8, 8'hA5);
    chkOuts("R9 R10 cmd req");
    rdChk("R10 status request nibble", 4'h8);

    // R5
    wrPort(4'hF, 8'hFA); chkOuts("R5 mask all");
    wrPort(4'hE, 8'h00); chkOuts("R5 mask clear");
    wrPort(4'hA, 8'h07); chkOuts("R4 mask set ch3");

    // R11 with pointer left high
    rdChk("R11 prep", 4'h6);
    wrPort(4'hD, 8'h00);
    chkOuts("R11 master clear");
    rdChk("R11 temp read", 4'hD);
    rdChk("R11 pointer low", 4'h6);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: begin
          logic [3:0] p;
          p = 4'($urandom_range(0, 7));
          wrPort(p, 8'($urandom)); wrPort(p, 8'($urandom));
        end
        1: stepCh(4'($urandom));
        2: begin
          logic [3:0] p;
          p = 4'($urandom_range(0, 7));
          rdChk("R1 R3 random read", p); rdChk("R1 R3 random read", p);
        end
        3: wrPort(4'hA, 8'($urandom));
        4: wrPort(4'hB, {2'($urandom_range(0, 2)), 6'($urandom)});
        5: rdChk("R9 random status", 4'h8);
        default: wrPort(4'($urandom_range(8, 15)), 8'($urandom));
      endcase
      if (it % 25 == 0) chkOuts("R6 R7 random outputs");
    end
    chkOuts("R7 final outputs");
    finishRun();
  end
endmodule